// File: doc/BRIEF.md
# Burst-of-Four QDR SRAM Command Sequencer

This block sits between the request queues of a memory controller and the physical output stage of a quad-data-rate static RAM. The RAM has separate read and write data ports, a shared address bus, and burst-of-four operation. Every clock cycle the sequencer puts exactly one command on the RAM pins. Read slots and write slots alternate, so a read and a write run side by side and two commands of the same kind never follow each other. A burst of four occupies its port for two clock cycles.

When a slot has no eligible request, the sequencer issues a dummy command to a fixed address with all byte-write enables inactive. This keeps the RAM in its active power mode. After reset it issues only dummy commands for a programmable warm-up period, so the RAM's internal clock circuit can lock.

Real reads are also held back while the calibration-done input is low. A request is popped from its queue in the same cycle its command appears on the pins. Write data leaves as two rising/falling word pairs on the two cycles after the write command. A strobe marks the cycle in which read data for a real read is due back from the RAM.

Top module: `qdr_b4_sequencer`

## Requirements
- R1: `rst` is a synchronous, active-high reset. While it is sampled high, and in the cycle after its last high sample, both selects (`mem_rd_n`, `mem_wr_n`) are high, `rd_pop`, `wr_pop` and `rd_data_due` are low, `mem_bw_n` is all ones, and both data buses are zero. Afterwards the sequencer restarts its warm-up.
- R2: Number the commands after reset release 1, 2, 3 and so on. Commands 1 to WAIT_CYCLES (default 10240) are dummies, and no queue is popped during them, even when requests are pending.
- R3: From the first command after reset, exactly one of `mem_rd_n` and `mem_wr_n` is low in each cycle. Odd-numbered commands are reads and even-numbered commands are writes, so no two consecutive commands have the same kind.
- R4: A dummy command drives `mem_addr` = DUMMY_ADDR (default 0). A dummy write's two data cycles drive `mem_bw_n` all ones and both data buses zero, and those buses show the same values on cycles that carry no write beat.
- R5: A read slot issues a real read when `rd_pending` is high, the warm-up is over and `cal_done` is high at that clock edge. In the cycle the command is on the pins, `rd_pop` is high and `mem_addr` equals the `rd_addr` presented.
- R6: While `cal_done` is low, every read slot issues a dummy read and `rd_pop` stays low. Write slots are not affected.
- R7: A write slot issues a real write when `wr_pending` is high and the warm-up is over, with no dependence on `cal_done`. In that cycle `wr_pop` is high and `mem_addr` equals `wr_addr`.
- R8: `wr_data` packs burst word i at bits [i*DATA_W +: DATA_W]. In the cycle after a real write command, `mem_d_rise`/`mem_d_fall` carry words 0/1, and in the cycle after that they carry words 2/3. `mem_bw_n` carries the request's `wr_be_n` in both cycles.
- R9: `rd_data_due` is high exactly two cycles after a cycle with a real read command on the pins, and low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| cal_done | input | 1 | Read capture calibration finished |
| rd_pending | input | 1 | Read queue holds a request |
| rd_addr | input | ADDR_W | Address of the oldest read request |
| rd_pop | output | 1 | Oldest read request consumed this cycle |
| wr_pending | input | 1 | Write queue holds a request |
| wr_addr | input | ADDR_W | Address of the oldest write request |
| wr_data | input | 4*DATA_W | Four burst words of the oldest write, word 0 lowest |
| wr_be_n | input | BE_W | Active-low byte-write enables of the oldest write |
| wr_pop | output | 1 | Oldest write request consumed this cycle |
| mem_rd_n | output | 1 | RAM read select, active low |
| mem_wr_n | output | 1 | RAM write select, active low |
| mem_addr | output | ADDR_W | Shared RAM address |
| mem_d_rise | output | DATA_W | Write word for the rising half of the cycle |
| mem_d_fall | output | DATA_W | Write word for the falling half of the cycle |
| mem_bw_n | output | BE_W | Byte-write enables for both halves, active low |
| rd_data_due | output | 1 | Read data of a real read returns from the RAM this cycle |

## Verification
The assertions assume a queue contract. The request fields hold steady while the matching pending flag is high and no pop has been seen. After a pop, the queue shows its next entry (or drops pending) before that slot comes round again. They also assume real requests never use DUMMY_ADDR, since the dummy-address checks read any non-popped command as a dummy. The bench models both queues itself: it advances a head pointer only on an observed pop and updates the request fields before the next edge. It never uses address zero for a real request, and it changes `cal_done` and `rst` only between edges.

// File: rtl/qdr_seq_pkg.sv
package qdr_seq_pkg;

  // Which port the current cycle serves
  typedef enum logic {
    SLOT_READ  = 1'b0,
    SLOT_WRITE = 1'b1
  } slot_e;

  // Active-low select pair driven to the RAM
  typedef struct packed {
    logic rd_sel_n;
    logic wr_sel_n;
  } sel_pair_t;

  function automatic sel_pair_t slot_selects(input slot_e s);
    sel_pair_t p;
    p.rd_sel_n = (s != SLOT_READ);
    p.wr_sel_n = (s != SLOT_WRITE);
    return p;
  endfunction

  function automatic slot_e next_slot(input slot_e s);
    return (s == SLOT_READ) ? SLOT_WRITE : SLOT_READ;
  endfunction

endpackage

// File: rtl/qdr_warmup_timer.sv
module qdr_warmup_timer #(
  parameter int unsigned WAIT_CYCLES = 10240
) (
  input  logic clk,
  input  logic rst,
  output logic warm_done
);
  localparam int unsigned CNT_W = $clog2(WAIT_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(WAIT_CYCLES);

  logic [CNT_W-1:0] cnt_q;

  // Saturating count of commands since reset
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (cnt_q != CNT_END) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign warm_done = (cnt_q == CNT_END);

endmodule

// File: rtl/qdr_slot_picker.sv
module qdr_slot_picker
  import qdr_seq_pkg::*;
#(
  parameter int unsigned       ADDR_W     = 20,
  parameter logic [ADDR_W-1:0] DUMMY_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              warm_done,
  input  logic              cal_done,
  input  logic              rd_pending,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              wr_pending,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic              mem_rd_n,
  output logic              mem_wr_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              rd_pop,
  output logic              wr_pop,
  output logic              burst_take,
  output logic              burst_real
);

  slot_e             slot_q;
  logic              rd_go;
  logic              wr_go;
  logic [ADDR_W-1:0] addr_d;
  sel_pair_t         sel_d;

  // Decide the command that leaves on the next edge
  always_comb begin
    rd_go = (slot_q == SLOT_READ)  && warm_done && cal_done && rd_pending;
    wr_go = (slot_q == SLOT_WRITE) && warm_done && wr_pending;
    sel_d = slot_selects(slot_q);
    if (slot_q == SLOT_READ) begin
      addr_d = rd_go ? rd_addr : DUMMY_ADDR;
    end else begin
      addr_d = wr_go ? wr_addr : DUMMY_ADDR;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_q   <= SLOT_READ;
      mem_rd_n <= 1'b1;
      mem_wr_n <= 1'b1;
      mem_addr <= '0;
      rd_pop   <= 1'b0;
      wr_pop   <= 1'b0;
    end else begin
      slot_q   <= next_slot(slot_q);
      mem_rd_n <= sel_d.rd_sel_n;
      mem_wr_n <= sel_d.wr_sel_n;
      mem_addr <= addr_d;
      rd_pop   <= rd_go;
      wr_pop   <= wr_go;
    end
  end

  // The data stager loads on every write slot, real or dummy
  assign burst_take = (slot_q == SLOT_WRITE);
  assign burst_real = wr_go;

endmodule

// File: rtl/qdr_wburst_stager.sv
module qdr_wburst_stager #(
  parameter int unsigned DATA_W = 18,
  parameter int unsigned BE_W   = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  burst_take,
  input  logic                  burst_real,
  input  logic [4*DATA_W-1:0]   wr_data,
  input  logic [BE_W-1:0]       wr_be_n,
  output logic [DATA_W-1:0]     mem_d_rise,
  output logic [DATA_W-1:0]     mem_d_fall,
  output logic [BE_W-1:0]       mem_bw_n
);
  localparam int unsigned WORDS   = 4;
  localparam int unsigned PAIRS   = WORDS / 2;
  localparam int unsigned BURST_W = WORDS * DATA_W;

  logic [BURST_W-1:0] hold_q;
  logic [BE_W-1:0]    hold_be_q;
  logic               first_q;
  logic               second_q;
  logic [DATA_W-1:0]  rise_w [PAIRS];
  logic [DATA_W-1:0]  fall_w [PAIRS];

  // Word pair p goes out in data cycle p: even word rising, odd word falling
  for (genvar p = 0; p < PAIRS; p++) begin : g_pair
    assign rise_w[p] = hold_q[(2*p)*DATA_W +: DATA_W];
    assign fall_w[p] = hold_q[(2*p+1)*DATA_W +: DATA_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q     <= '0;
      hold_be_q  <= '1;
      first_q    <= 1'b0;
      second_q   <= 1'b0;
      mem_d_rise <= '0;
      mem_d_fall <= '0;
      mem_bw_n   <= '1;
    end else begin
      if (burst_take) begin
        hold_q    <= burst_real ? wr_data : '0;
        hold_be_q <= burst_real ? wr_be_n : '1;
      end
      first_q  <= burst_take;
      second_q <= first_q;
      if (first_q) begin
        mem_d_rise <= rise_w[0];
        mem_d_fall <= fall_w[0];
        mem_bw_n   <= hold_be_q;
      end else if (second_q) begin
        mem_d_rise <= rise_w[1];
        mem_d_fall <= fall_w[1];
        mem_bw_n   <= hold_be_q;
      end else begin
        mem_d_rise <= '0;
        mem_d_fall <= '0;
        mem_bw_n   <= '1;
      end
    end
  end

endmodule

// File: rtl/qdr_rd_return_tracker.sv
module qdr_rd_return_tracker #(
  parameter int unsigned RD_LATENCY = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rd_issued,
  output logic rd_data_due
);
  logic [RD_LATENCY-1:0] pipe_q;

  if (RD_LATENCY == 1) begin : g_one
    always_ff @(posedge clk) begin
      if (rst) pipe_q <= '0;
      else     pipe_q <= rd_issued;
    end
  end else begin : g_many
    always_ff @(posedge clk) begin
      if (rst) pipe_q <= '0;
      else     pipe_q <= {pipe_q[RD_LATENCY-2:0], rd_issued};
    end
  end

  assign rd_data_due = pipe_q[RD_LATENCY-1];

endmodule

// File: rtl/qdr_b4_sequencer.sv
module qdr_b4_sequencer #(
  parameter int unsigned       ADDR_W      = 20,
  parameter int unsigned       DATA_W      = 18,
  parameter int unsigned       BE_W        = 2,
  parameter int unsigned       WAIT_CYCLES = 10240,
  parameter int unsigned       RD_LATENCY  = 2,
  parameter logic [ADDR_W-1:0] DUMMY_ADDR  = '0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cal_done,
  input  logic                rd_pending,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic                rd_pop,
  input  logic                wr_pending,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [4*DATA_W-1:0] wr_data,
  input  logic [BE_W-1:0]     wr_be_n,
  output logic                wr_pop,
  output logic                mem_rd_n,
  output logic                mem_wr_n,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [DATA_W-1:0]   mem_d_rise,
  output logic [DATA_W-1:0]   mem_d_fall,
  output logic [BE_W-1:0]     mem_bw_n,
  output logic                rd_data_due
);

  logic warm_done;
  logic burst_take;
  logic burst_real;

  qdr_warmup_timer #(
    .WAIT_CYCLES (WAIT_CYCLES)
  ) u_warm (
    .clk       (clk),
    .rst       (rst),
    .warm_done (warm_done)
  );

  qdr_slot_picker #(
    .ADDR_W     (ADDR_W),
    .DUMMY_ADDR (DUMMY_ADDR)
  ) u_pick (
    .clk        (clk),
    .rst        (rst),
    .warm_done  (warm_done),
    .cal_done   (cal_done),
    .rd_pending (rd_pending),
    .rd_addr    (rd_addr),
    .wr_pending (wr_pending),
    .wr_addr    (wr_addr),
    .mem_rd_n   (mem_rd_n),
    .mem_wr_n   (mem_wr_n),
    .mem_addr   (mem_addr),
    .rd_pop     (rd_pop),
    .wr_pop     (wr_pop),
    .burst_take (burst_take),
    .burst_real (burst_real)
  );

  qdr_wburst_stager #(
    .DATA_W (DATA_W),
    .BE_W   (BE_W)
  ) u_wdat (
    .clk        (clk),
    .rst        (rst),
    .burst_take (burst_take),
    .burst_real (burst_real),
    .wr_data    (wr_data),
    .wr_be_n    (wr_be_n),
    .mem_d_rise (mem_d_rise),
    .mem_d_fall (mem_d_fall),
    .mem_bw_n   (mem_bw_n)
  );

  // rd_pop is high exactly in cycles holding a real read on the pins
  qdr_rd_return_tracker #(
    .RD_LATENCY (RD_LATENCY)
  ) u_rret (
    .clk         (clk),
    .rst         (rst),
    .rd_issued   (rd_pop),
    .rd_data_due (rd_data_due)
  );

endmodule

// File: rtl/qdr_seq_checker.sv
module qdr_seq_checker #(
  parameter int unsigned       ADDR_W      = 20,
  parameter int unsigned       BE_W        = 2,
  parameter int unsigned       WAIT_CYCLES = 10240,
  parameter logic [ADDR_W-1:0] DUMMY_ADDR  = '0
) (
  input logic              clk,
  input logic              rst,
  input logic              cal_done,
  input logic              rd_pop,
  input logic              wr_pop,
  input logic              mem_rd_n,
  input logic              mem_wr_n,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [BE_W-1:0]   mem_bw_n,
  input logic              rd_data_due
);
  localparam int unsigned CW = $clog2(WAIT_CYCLES + 2);
  localparam logic [CW-1:0] CHK_END = CW'(WAIT_CYCLES + 1);

  logic [CW-1:0] seen_q;

  // Own count of commands since reset, for the warm-up window
  always_ff @(posedge clk) begin
    if (rst) seen_q <= '0;
    else if (seen_q != CHK_END) seen_q <= seen_q + 1'b1;
  end

  assert_one_select_R3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (mem_rd_n != mem_wr_n));

  assert_no_read_pair_R3: assert property (@(posedge clk) disable iff (rst)
    !mem_rd_n |=> mem_rd_n);

  assert_no_write_pair_R3: assert property (@(posedge clk) disable iff (rst)
    !mem_wr_n |=> mem_wr_n);

  assert_warmup_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    (seen_q <= CW'(WAIT_CYCLES)) |-> (!rd_pop && !wr_pop));

  assert_dummy_read_addr_R4: assert property (@(posedge clk) disable iff (rst)
    (!mem_rd_n && !rd_pop) |-> (mem_addr == DUMMY_ADDR));

  assert_dummy_write_addr_R4: assert property (@(posedge clk) disable iff (rst)
    (!mem_wr_n && !wr_pop) |-> (mem_addr == DUMMY_ADDR));

  assert_dummy_write_masked_R4: assert property (@(posedge clk) disable iff (rst)
    (!mem_wr_n && !wr_pop) |=> (&mem_bw_n));

  assert_rd_pop_with_cmd_R5: assert property (@(posedge clk) disable iff (rst)
    rd_pop |-> !mem_rd_n);

  assert_rd_needs_cal_R6: assert property (@(posedge clk) disable iff (rst)
    rd_pop |-> $past(cal_done));

  assert_wr_pop_with_cmd_R7: assert property (@(posedge clk) disable iff (rst)
    wr_pop |-> !mem_wr_n);

  assert_read_return_R9: assert property (@(posedge clk) disable iff (rst)
    rd_pop |=> ##1 rd_data_due);

endmodule

bind qdr_b4_sequencer qdr_seq_checker #(
  .ADDR_W      (ADDR_W),
  .BE_W        (BE_W),
  .WAIT_CYCLES (WAIT_CYCLES),
  .DUMMY_ADDR  (DUMMY_ADDR)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cal_done    (cal_done),
  .rd_pop      (rd_pop),
  .wr_pop      (wr_pop),
  .mem_rd_n    (mem_rd_n),
  .mem_wr_n    (mem_wr_n),
  .mem_addr    (mem_addr),
  .mem_bw_n    (mem_bw_n),
  .rd_data_due (rd_data_due)
);

// File: tb/sim_qdr_b4_sequencer.sv
module sim_qdr_b4_sequencer;
  localparam int AW = 20, DW = 18, BW = 2, WAIT = 10240;
  localparam int QD = 64, MAX_CYC = 60000, NV = 8;

  // Vector: {read addr, write addr, word seed, byte-enable_n}; word i = {seed, i}
  localparam logic [57:0] VEC [0:NV-1] = '{
    {20'h00101, 20'h00201, 16'hA001, 2'b00},
    {20'h00102, 20'h00202, 16'hB012, 2'b01},
    {20'h00103, 20'h00203, 16'hC123, 2'b10},
    {20'h3FF04, 20'h3FF05, 16'hD234, 2'b00},
    {20'h00F05, 20'h0E006, 16'h0E45, 2'b00},
    {20'h12306, 20'h45607, 16'h5F56, 2'b11},
    {20'h00007, 20'h00008, 16'h6067, 2'b00},
    {20'hFFFFF, 20'h80000, 16'hFFFF, 2'b01}
  };

  logic clk = 1'b0, rst = 1'b1, cal_done = 1'b0;
  logic rd_pending = 1'b0, wr_pending = 1'b0;
  logic [AW-1:0] rd_addr = '0, wr_addr = '0;
  logic [4*DW-1:0] wr_data = '0;
  logic [BW-1:0] wr_be_n = '1;
  logic rd_pop, wr_pop, mem_rd_n, mem_wr_n, rd_data_due;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_d_rise, mem_d_fall;
  logic [BW-1:0] mem_bw_n;

  always #5 clk = ~clk;

  qdr_b4_sequencer u0 (
    .clk(clk), .rst(rst), .cal_done(cal_done),
    .rd_pending(rd_pending), .rd_addr(rd_addr), .rd_pop(rd_pop),
    .wr_pending(wr_pending), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_be_n(wr_be_n), .wr_pop(wr_pop),
    .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n), .mem_addr(mem_addr),
    .mem_d_rise(mem_d_rise), .mem_d_fall(mem_d_fall), .mem_bw_n(mem_bw_n),
    .rd_data_due(rd_data_due)
  );

  // Queue models
  logic [AW-1:0]   rq_a [0:QD-1];
  logic [AW-1:0]   wq_a [0:QD-1];
  logic [4*DW-1:0] wq_d [0:QD-1];
  logic [BW-1:0]   wq_b [0:QD-1];
  int rh = 0, rt = 0, wh = 0, wt = 0;

  int total = 0, bad = 0, cyc = 0, k = 0, beat = 0;
  bit timeout = 0;
  logic [1:0] rd_hist = '0;
  logic [4*DW-1:0] b_data = '0;
  logic [BW-1:0] b_be = '1;

  task automatic chk(input bit ok, input string tag, input logic [95:0] act, input logic [95:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s cmd=%0d actual=%0h expected=%0h", tag, k, act, exp);
    end
  endtask

  task automatic set_ports();
    rd_pending = (rt != rh);
    rd_addr    = (rt != rh) ? rq_a[rh % QD] : '0;
    wr_pending = (wt != wh);
    wr_addr    = (wt != wh) ? wq_a[wh % QD] : '0;
    wr_data    = (wt != wh) ? wq_d[wh % QD] : '0;
    wr_be_n    = (wt != wh) ? wq_b[wh % QD] : '1;
  endtask

  function automatic logic [4*DW-1:0] burst_of(input logic [15:0] seed);
    return {seed, 2'd3, seed, 2'd2, seed, 2'd1, seed, 2'd0};
  endfunction

  task automatic push_rd(input logic [AW-1:0] a);
    rq_a[rt % QD] = a; rt++; set_ports();
  endtask

  task automatic push_wr(input logic [AW-1:0] a, input logic [15:0] seed, input logic [BW-1:0] be);
    wq_a[wt % QD] = a; wq_d[wt % QD] = burst_of(seed); wq_b[wt % QD] = be; wt++; set_ports();
  endtask

  // One cycle: sample at the falling edge, compare with the model, advance the queues
  task automatic step();
    bit is_rd, exp_rd, exp_wr;
    logic [AW-1:0] exp_a;
    logic [DW-1:0] er, ef;
    logic [BW-1:0] eb;
    @(negedge clk);
    cyc++;
    if (cyc > MAX_CYC) timeout = 1;
    if (rst) begin
      k = 0; rd_hist = '0; beat = 0;
      chk(mem_rd_n && mem_wr_n, "R1 selects idle in reset", {mem_rd_n, mem_wr_n}, 2'b11);
      chk(!rd_pop && !wr_pop && !rd_data_due, "R1 pops and due low in reset",
          {rd_pop, wr_pop, rd_data_due}, 3'b000);
      chk(mem_bw_n == '1 && mem_d_rise == '0 && mem_d_fall == '0, "R1 write data idle in reset",
          {mem_bw_n, mem_d_rise, mem_d_fall}, {2'b11, 36'd0});
    end else begin
      k++;
      is_rd = (k % 2) == 1;
      chk(mem_rd_n == !is_rd && mem_wr_n == is_rd, "R3 alternating select",
          {mem_rd_n, mem_wr_n}, {!is_rd, is_rd});
      exp_rd = is_rd && (k > WAIT) && (rt != rh) && cal_done;
      exp_wr = !is_rd && (k > WAIT) && (wt != wh);
      chk(rd_pop == exp_rd,
          (k <= WAIT) ? "R2 no read pop in warm-up" : (!cal_done ? "R6 read held" : "R5 read pop"),
          rd_pop, exp_rd);
      chk(wr_pop == exp_wr, (k <= WAIT) ? "R2 no write pop in warm-up" : "R7 write pop",
          wr_pop, exp_wr);
      if (is_rd) exp_a = exp_rd ? rq_a[rh % QD] : '0;
      else       exp_a = exp_wr ? wq_a[wh % QD] : '0;
      chk(mem_addr == exp_a, (exp_rd || exp_wr) ? "R5 R7 request address" : "R4 dummy address",
          mem_addr, exp_a);
      // expected write-data beats
      if (beat == 1) begin
        er = b_data[0 +: DW]; ef = b_data[DW +: DW]; eb = b_be; beat = 2;
      end else if (beat == 2) begin
        er = b_data[2*DW +: DW]; ef = b_data[3*DW +: DW]; eb = b_be; beat = 0;
      end else begin
        er = '0; ef = '0; eb = '1;
      end
      chk(mem_d_rise == er && mem_d_fall == ef && mem_bw_n == eb, "R8 R4 write data beat",
          {mem_bw_n, mem_d_rise, mem_d_fall}, {eb, er, ef});
      chk(rd_data_due == rd_hist[1], "R9 read return strobe", rd_data_due, rd_hist[1]);
      rd_hist = {rd_hist[0], exp_rd};
      if (!is_rd) begin
        b_data = exp_wr ? wq_d[wh % QD] : '0;
        b_be   = exp_wr ? wq_b[wh % QD] : '1;
        beat   = 1;
      end
      if (rd_pop) rh++;
      if (wr_pop) wh++;
      set_ports();
    end
  endtask

  task automatic drain(input int limit, input string tag);
    int n = 0;
    while (((rt != rh) || (wt != wh)) && n < limit && !timeout) begin
      step(); n++;
    end
    repeat (4) step();
    chk(rt == rh && wt == wh, tag, {rt - rh, wt - wh}, 64'd0);
  endtask

  initial begin
    cal_done = 1'b1;
    set_ports();
    repeat (3) step();
    // table walk: queue every vector while still in reset
    for (int i = 0; i < NV; i++) begin
      push_rd(VEC[i][57:38]);
      push_wr(VEC[i][37:18], VEC[i][17:2], VEC[i][1:0]);
    end
    step();
    rst = 1'b0;
    drain(WAIT + 200, "R2 R5 R7 table drained after warm-up");

    // calibration not done: reads wait, writes go
    cal_done = 1'b0;
    push_rd(20'h00A01); push_rd(20'h00A02); push_rd(20'h00A03);
    push_wr(20'h00B01, 16'h1357, 2'b10); push_wr(20'h00B02, 16'h2468, 2'b00);
    repeat (20) step();
    chk((rt - rh) == 3, "R6 reads held while calibration pending", rt - rh, 3);
    chk(wt == wh, "R7 writes proceed without calibration", wt - wh, 0);
    cal_done = 1'b1;
    drain(100, "R5 held reads issued after calibration");

    // idle keep-alive
    repeat (20) step();

    // reads only, then writes only
    for (int i = 0; i < 4; i++) push_rd(AW'(20'h05000 + i));
    drain(100, "R5 read-only stream");
    push_wr(20'h06001, 16'h0F0F, 2'b01);
    push_wr(20'h06002, 16'hF0F0, 2'b10);
    push_wr(20'h06003, 16'h3C3C, 2'b00);
    drain(100, "R8 write-only stream");

    // calibration drops mid-stream
    for (int i = 0; i < 4; i++) push_rd(AW'(20'h07000 + i));
    step();
    cal_done = 1'b0;
    repeat (3) step();
    cal_done = 1'b1;
    drain(100, "R6 stream resumes after calibration returns");

    // reset in the middle of traffic restarts the warm-up
    push_rd(20'h08001); push_rd(20'h08002);
    push_wr(20'h09001, 16'h7777, 2'b00); push_wr(20'h09002, 16'h8888, 2'b01);
    rst = 1'b1;
    repeat (3) step();
    rst = 1'b0;
    drain(WAIT + 100, "R1 R2 traffic after second reset");

    if (timeout) begin
      bad++;
      total++;
      $display("FAIL watchdog expired after %0d cycles, expected under %0d", cyc, MAX_CYC);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule